// File: doc/BRIEF.md
# DMA Address Translation Mapper

This block sits between DMA-capable devices and the system bus. A device presents a 24-bit DMA address. The mapper looks up a page descriptor for the 8 KiB page that holds that address. It then returns a 32-bit system bus address, two page attributes and a fault code. The descriptor table has one entry per DMA page, 2048 entries in all. It lives in a dual-port memory. The CPU port reads and writes whole descriptor words by entry number. The DMA port issues one lookup per request strobe.

A descriptor holds a 19-bit physical frame, a cache-inhibit flag, a whole-block-write flag (writes to the page fill complete 16-byte aligned blocks), a write-protect flag and a two-bit type code. Six spare bits are stored but play no part in translation. The mapper keeps two bookkeeping flags per page. The accessed flag is set by every successful lookup. The dirty flag is set by every successful write lookup. Both flags are visible in CPU readback.

A device with fewer than 24 address lines is wired to the top of the DMA space. The requester gives its address width with each request, and every address bit at or above that width is forced to one before the lookup.

Top module: `dma_xlate_mapper`

## Requirements
- R1: After reset, with no request pending, `rsp_valid` and `cpu_rvalid` are low.
- R2: A CPU read (`cpu_en`=1, `cpu_we`=0) raises `cpu_rvalid` in the next cycle. `cpu_rdata` then holds the stored word, with spare bits 12..7 exactly as last written. Bits 4 (dirty) and 3 (accessed) show the current bookkeeping flags.
- R3: A lookup on `dma_req` raises `rsp_valid` for exactly one cycle, in the next cycle. The entry is selected by bits 23..13 of the extended address.
- R4: On a successful lookup, `rsp_addr` is descriptor bits 31..13 followed by extended address bits 12..0. `rsp_ci` is descriptor bit 6 and `rsp_bx` is descriptor bit 5.
- R5: Type code 00 (bits 1..0) gives fault code 01. Whenever the fault code is nonzero, `rsp_addr`, `rsp_ci` and `rsp_bx` are zero.
- R6: Type code 10 or 11 gives fault code 10. This takes priority over write protection.
- R7: With type 01 and bit 2 (write protect) set, a write lookup gives fault code 11 and a read lookup succeeds. Fault code 00 means success.
- R8: Every address bit at a position at or above `dma_aw` is forced to one before the lookup. A width of 24 or more leaves the address unchanged.
- R9: A successful lookup sets the entry's accessed flag. A successful write lookup also sets its dirty flag. A faulted lookup changes neither flag. The update shows in a CPU read issued after the response cycle.
- R10: A CPU write and a lookup to the same entry in the same cycle: the lookup uses the newly written descriptor.
- R11: Spare bits 12..7 have no effect on translation results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU access is a write |
| cpu_idx | input | 11 | Descriptor entry number |
| cpu_wdata | input | 32 | Descriptor word to store |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 32 | Descriptor word read back |
| dma_req | input | 1 | Lookup request strobe |
| dma_wr | input | 1 | Lookup is for a DMA write |
| dma_addr | input | 24 | Device DMA address |
| dma_aw | input | 5 | Device address width in bits |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_addr | output | 32 | Translated system bus address |
| rsp_ci | output | 1 | Cache-inhibit attribute |
| rsp_bx | output | 1 | Whole-block-write attribute |
| rsp_fault | output | 2 | 00 ok, 01 invalid, 10 malformed, 11 protected |

## Verification
The descriptor memory is not reset. The assertions and the data checks therefore rely on every entry that a lookup reaches having been written by the CPU first. The stimulus writes each target entry, including the top-of-space entries reached by narrow devices, before it looks that entry up. The offset assertion assumes the device width is at least the page-offset width; narrower widths force offset bits, and only the scoreboard checks those cases. CPU readbacks of bookkeeping flags are placed at least one idle cycle after the response they depend on, so they never collide with the flag update.

// File: rtl/dxm_pkg.sv
package dxm_pkg;
  localparam int BIT_CI  = 6;
  localparam int BIT_BX  = 5;
  localparam int BIT_MOD = 4;
  localparam int BIT_USE = 3;
  localparam int BIT_WP  = 2;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_INVALID = 2'b01,
    FLT_BADTYPE = 2'b10,
    FLT_PROTECT = 2'b11
  } fault_e;
endpackage

// File: rtl/dxm_desc_ram.sv
module dxm_desc_ram #(
  parameter int IDX_W = 11,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [DW-1:0]    a_wdata,
  output logic [DW-1:0]    a_rdata,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  output logic [DW-1:0]    b_rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  // read-first on both ports; same-cycle forwarding is handled by the owner
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_idx] <= a_wdata;
      a_rdata <= mem[a_idx];
    end
    if (b_en) b_rdata <= mem[b_idx];
  end
endmodule

// File: rtl/dxm_um_track.sv
module dxm_um_track #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             cpu_use,
  input  logic             cpu_mod,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_mod,
  output logic             rd_use,
  output logic             rd_mod
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] use_q;
  logic [DEPTH-1:0] mod_q;
  logic             set_ok;

  // a CPU write to the same entry on the same edge wins over the flag update
  assign set_ok = set_en && !(cpu_wr && (cpu_idx == set_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      use_q  <= '0;
      mod_q  <= '0;
      rd_use <= 1'b0;
      rd_mod <= 1'b0;
    end else begin
      if (set_ok) begin
        use_q[set_idx] <= 1'b1;
        if (set_mod) mod_q[set_idx] <= 1'b1;
      end
      if (cpu_wr) begin
        use_q[cpu_idx] <= cpu_use;
        mod_q[cpu_idx] <= cpu_mod;
      end
      if (cpu_rd) begin
        rd_use <= use_q[cpu_idx];
        rd_mod <= mod_q[cpu_idx];
      end
    end
  end
endmodule

// File: rtl/dxm_addr_ext.sv
module dxm_addr_ext #(
  parameter int DMA_AW = 24,
  parameter int AW_W   = 5
) (
  input  logic [DMA_AW-1:0] dma_addr,
  input  logic [AW_W-1:0]   dev_aw,
  output logic [DMA_AW-1:0] ext_addr
);
  // lines above the device width are tied high: device sits at top of space
  for (genvar b = 0; b < DMA_AW; b++) begin : g_bit
    assign ext_addr[b] = dma_addr[b] | (int'(dev_aw) <= b);
  end
endmodule

// File: rtl/dxm_fault_eval.sv
module dxm_fault_eval
  import dxm_pkg::*;
#(
  parameter int SYS_AW    = 32,
  parameter int PAGE_BITS = 13
) (
  input  logic [SYS_AW-1:0]    desc,
  input  logic                 is_wr,
  input  logic [PAGE_BITS-1:0] offset,
  output fault_e               fault,
  output logic [SYS_AW-1:0]    addr,
  output logic                 ci,
  output logic                 bx
);
  logic ok;
  logic unused_desc_bits;

  assign unused_desc_bits = ^{desc[PAGE_BITS-1:BIT_CI+1], desc[BIT_MOD:BIT_USE]};

  always_comb begin
    if (desc[1])
      fault = FLT_BADTYPE;
    else if (!desc[0])
      fault = FLT_INVALID;
    else if (is_wr && desc[BIT_WP])
      fault = FLT_PROTECT;
    else
      fault = FLT_NONE;
    ok   = (fault == FLT_NONE);
    addr = ok ? {desc[SYS_AW-1:PAGE_BITS], offset} : '0;
    ci   = ok && desc[BIT_CI];
    bx   = ok && desc[BIT_BX];
  end
endmodule

// File: rtl/dma_xlate_mapper.sv
module dma_xlate_mapper
  import dxm_pkg::*;
#(
  parameter int DMA_AW    = 24,
  parameter int SYS_AW    = 32,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = DMA_AW - PAGE_BITS,
  parameter int AW_W      = $clog2(DMA_AW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_en,
  input  logic              cpu_we,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [SYS_AW-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [SYS_AW-1:0] cpu_rdata,
  input  logic              dma_req,
  input  logic              dma_wr,
  input  logic [DMA_AW-1:0] dma_addr,
  input  logic [AW_W-1:0]   dma_aw,
  output logic              rsp_valid,
  output logic [SYS_AW-1:0] rsp_addr,
  output logic              rsp_ci,
  output logic              rsp_bx,
  output logic [1:0]        rsp_fault
);
  logic                 cpu_wr;
  logic                 cpu_rd;
  logic [DMA_AW-1:0]    ext_addr;
  logic [IDX_W-1:0]     dma_idx;
  logic [SYS_AW-1:0]    ram_a_q;
  logic [SYS_AW-1:0]    ram_b_q;
  logic                 req_q;
  logic                 wr_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 byp_q;
  logic [SYS_AW-1:0]    byp_data_q;
  logic                 rvalid_q;
  logic [SYS_AW-1:0]    desc_sel;
  fault_e               fault;
  logic                 rd_use;
  logic                 rd_mod;
  logic                 unused_ram_flags;

  assign cpu_wr = cpu_en && cpu_we;
  assign cpu_rd = cpu_en && !cpu_we;

  dxm_addr_ext #(.DMA_AW(DMA_AW), .AW_W(AW_W)) u_ext (
    .dma_addr (dma_addr),
    .dev_aw   (dma_aw),
    .ext_addr (ext_addr)
  );

  assign dma_idx = ext_addr[DMA_AW-1:PAGE_BITS];

  dxm_desc_ram #(.IDX_W(IDX_W), .DW(SYS_AW)) u_ram (
    .clk     (clk),
    .a_en    (cpu_en),
    .a_we    (cpu_we),
    .a_idx   (cpu_idx),
    .a_wdata (cpu_wdata),
    .a_rdata (ram_a_q),
    .b_en    (dma_req),
    .b_idx   (dma_idx),
    .b_rdata (ram_b_q)
  );

  // request stage: capture context and note a same-entry CPU write
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      wr_q       <= 1'b0;
      off_q      <= '0;
      idx_q      <= '0;
      byp_q      <= 1'b0;
      byp_data_q <= '0;
      rvalid_q   <= 1'b0;
    end else begin
      req_q    <= dma_req;
      rvalid_q <= cpu_rd;
      if (dma_req) begin
        wr_q       <= dma_wr;
        off_q      <= ext_addr[PAGE_BITS-1:0];
        idx_q      <= dma_idx;
        byp_q      <= cpu_wr && (cpu_idx == dma_idx);
        byp_data_q <= cpu_wdata;
      end
    end
  end

  assign desc_sel = byp_q ? byp_data_q : ram_b_q;

  dxm_fault_eval #(.SYS_AW(SYS_AW), .PAGE_BITS(PAGE_BITS)) u_eval (
    .desc   (desc_sel),
    .is_wr  (wr_q),
    .offset (off_q),
    .fault  (fault),
    .addr   (rsp_addr),
    .ci     (rsp_ci),
    .bx     (rsp_bx)
  );

  dxm_um_track #(.IDX_W(IDX_W)) u_um (
    .clk     (clk),
    .rst     (rst),
    .cpu_wr  (cpu_wr),
    .cpu_rd  (cpu_rd),
    .cpu_idx (cpu_idx),
    .cpu_use (cpu_wdata[BIT_USE]),
    .cpu_mod (cpu_wdata[BIT_MOD]),
    .set_en  (req_q && (fault == FLT_NONE)),
    .set_idx (idx_q),
    .set_mod (wr_q),
    .rd_use  (rd_use),
    .rd_mod  (rd_mod)
  );

  assign unused_ram_flags = ^ram_a_q[BIT_MOD:BIT_USE];

  assign rsp_valid  = req_q;
  assign rsp_fault  = fault;
  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = {ram_a_q[SYS_AW-1:BIT_MOD+1], rd_mod, rd_use, ram_a_q[BIT_WP:0]};
endmodule

// File: rtl/dxm_checker.sv
module dxm_checker #(
  parameter int DMA_AW    = 24,
  parameter int SYS_AW    = 32,
  parameter int PAGE_BITS = 13,
  parameter int AW_W      = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_en,
  input logic              cpu_we,
  input logic              cpu_rvalid,
  input logic              dma_req,
  input logic              dma_wr,
  input logic [DMA_AW-1:0] dma_addr,
  input logic [AW_W-1:0]   dma_aw,
  input logic              rsp_valid,
  input logic [SYS_AW-1:0] rsp_addr,
  input logic              rsp_ci,
  input logic              rsp_bx,
  input logic [1:0]        rsp_fault
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> rsp_valid); // R3

  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    !dma_req |=> !rsp_valid); // R3

  AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_addr == '0 && !rsp_ci && !rsp_bx)); // R5

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (dma_req && int'(dma_aw) >= PAGE_BITS) |=>
      (rsp_fault != 2'b00 || rsp_addr[PAGE_BITS-1:0] == $past(dma_addr[PAGE_BITS-1:0]))); // R4

  AST_READ_NOT_PROT: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_wr) |=> rsp_fault != 2'b11); // R7

  AST_CPU_RVALID: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && !cpu_we) |=> cpu_rvalid); // R2
endmodule

bind dma_xlate_mapper dxm_checker #(
  .DMA_AW(DMA_AW), .SYS_AW(SYS_AW), .PAGE_BITS(PAGE_BITS), .AW_W(AW_W)
) u_chk (
  .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_rvalid(cpu_rvalid),
  .dma_req(dma_req), .dma_wr(dma_wr), .dma_addr(dma_addr), .dma_aw(dma_aw),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_ci(rsp_ci), .rsp_bx(rsp_bx),
  .rsp_fault(rsp_fault)
);

// File: tb/dma_xlate_mapper_tb.sv
`timescale 1ns/1ps
module dma_xlate_mapper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_en = 1'b0;
  logic        cpu_we = 1'b0;
  logic [10:0] cpu_idx = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        dma_req = 1'b0;
  logic        dma_wr = 1'b0;
  logic [23:0] dma_addr = '0;
  logic [4:0]  dma_aw = 5'd24;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_ci;
  logic        rsp_bx;
  logic [1:0]  rsp_fault;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] shadow [2048];
  logic [35:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  dma_xlate_mapper u_dut (
    .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .dma_req(dma_req), .dma_wr(dma_wr), .dma_addr(dma_addr), .dma_aw(dma_aw),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_ci(rsp_ci), .rsp_bx(rsp_bx),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [31:0] mk(input logic [18:0] fr, input logic [5:0] sp,
                                     input logic ci, input logic bx, input logic wp,
                                     input logic [1:0] ty);
    return {fr, sp, ci, bx, 1'b0, 1'b0, wp, ty};
  endfunction

  function automatic logic [23:0] extend(input logic [23:0] a, input int aw);
    logic [23:0] e;
    for (int b = 0; b < 24; b++) e[b] = a[b] | (b >= aw);
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // expected result per the requirements; also updates the shadow flags
  task automatic predict(input logic [23:0] a, input int aw, input logic wr,
                         input string tag);
    logic [23:0] e;
    logic [31:0] d;
    logic [1:0]  f;
    logic [10:0] ix;
    e  = extend(a, aw);
    ix = e[23:13];
    d  = shadow[ix];
    if (d[1]) f = 2'b10;
    else if (!d[0]) f = 2'b01;
    else if (wr && d[2]) f = 2'b11;
    else f = 2'b00;
    if (f != 2'b00) exp_q.push_back({f, 2'b00, 32'h0});
    else begin
      exp_q.push_back({f, d[6], d[5], d[31:13], e[12:0]});
      shadow[ix][3] = 1'b1;
      if (wr) shadow[ix][4] = 1'b1;
    end
    tag_q.push_back(tag);
  endtask

  task automatic cpu_write(input int idx, input logic [31:0] d);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_idx = 11'(idx); cpu_wdata = d;
    shadow[idx] = d;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input int idx, input string tag);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_idx = 11'(idx);
    @(negedge clk);
    cpu_en = 1'b0;
    check(cpu_rvalid === 1'b1 && cpu_rdata === shadow[idx], tag,
          {3'b0, cpu_rvalid, cpu_rdata}, {4'b0001, shadow[idx]});
  endtask

  task automatic lookup(input logic [23:0] a, input int aw, input logic wr,
                        input string tag);
    predict(a, aw, wr, tag);
    dma_req = 1'b1; dma_wr = wr; dma_addr = a; dma_aw = 5'(aw);
    @(negedge clk);
    dma_req = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected response", {rsp_fault, rsp_ci, rsp_bx, rsp_addr}, 36'h0);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_fault, rsp_ci, rsp_bx, rsp_addr} === e, t,
              {rsp_fault, rsp_ci, rsp_bx, rsp_addr}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid", {35'b0, rsp_valid}, 36'h0);
    check(cpu_rvalid === 1'b0, "R1 cpu_rvalid", {35'b0, cpu_rvalid}, 36'h0);

    cpu_write(5,  mk(19'h12345, 6'h2A, 1'b1, 1'b0, 1'b0, 2'b01));
    cpu_write(6,  mk(19'h7FFFF, 6'h00, 1'b0, 1'b1, 1'b1, 2'b01));
    cpu_write(7,  mk(19'h00111, 6'h15, 1'b1, 1'b1, 1'b0, 2'b00));
    cpu_write(8,  mk(19'h00222, 6'h00, 1'b0, 1'b0, 1'b0, 2'b10));
    cpu_write(9,  mk(19'h00333, 6'h3F, 1'b1, 1'b0, 1'b1, 2'b11));
    cpu_write(10, mk(19'h12345, 6'h00, 1'b1, 1'b0, 1'b0, 2'b01));
    cpu_write(11, mk(19'h40001, 6'h01, 1'b0, 1'b1, 1'b0, 2'b01));
    cpu_write(20, mk(19'h0DEAD, 6'h00, 1'b0, 1'b0, 1'b0, 2'b00));
    cpu_write(12'h7F9, mk(19'h55555, 6'h00, 1'b0, 1'b1, 1'b0, 2'b01));
    cpu_write(12'h7FF, mk(19'h2AAAA, 6'h00, 1'b1, 1'b0, 1'b0, 2'b01));
    @(negedge clk);

    cpu_read(5, "R2 spare bits readback");
    cpu_read(9, "R2 readback all spare set");

    lookup({11'd5, 13'h0123}, 24, 1'b0, "R4 read translate");
    lookup({11'd5, 13'h1FFF}, 24, 1'b1, "R4 write translate");
    lookup({11'd6, 13'h0800}, 24, 1'b0, "R7 protected page read ok");
    lookup({11'd6, 13'h0801}, 24, 1'b1, "R7 protected page write");
    lookup({11'd7, 13'h0004}, 24, 1'b0, "R5 invalid read");
    lookup({11'd7, 13'h0005}, 24, 1'b1, "R5 invalid write");
    lookup({11'd8, 13'h0000}, 24, 1'b0, "R6 type 10");
    lookup({11'd9, 13'h0FF0}, 24, 1'b1, "R6 type 11 over protect");
    lookup({11'd10, 13'h0123}, 24, 1'b0, "R11 spare bits ignored");
    lookup({11'd11, 13'h1000}, 24, 1'b1, "R4 write with bx");
    lookup(24'h002468, 16, 1'b0, "R8 width 16");
    lookup(24'h000ABC, 13, 1'b1, "R8 width 13");
    lookup(24'h000123, 10, 1'b0, "R8 width 10 forces offset");
    lookup({11'd5, 13'h0042}, 31, 1'b0, "R8 width 31 unchanged");

    // same-cycle CPU write and lookup of entry 20
    shadow[20] = mk(19'h00ABC, 6'h00, 1'b0, 1'b1, 1'b0, 2'b01);
    predict({11'd20, 13'h0010}, 24, 1'b0, "R10 write forwarded to lookup");
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_idx = 11'd20; cpu_wdata = shadow[20] & ~32'h18;
    dma_req = 1'b1; dma_wr = 1'b0; dma_addr = {11'd20, 13'h0010}; dma_aw = 5'd24;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0; dma_req = 1'b0;
    @(negedge clk);
    @(negedge clk);

    cpu_read(5,  "R9 accessed and dirty set");
    cpu_read(6,  "R9 accessed only after read");
    cpu_read(7,  "R9 faulted page unchanged");
    cpu_read(9,  "R9 malformed page unchanged");
    cpu_read(11, "R9 write sets both");
    cpu_read(12'h7FF, "R9 narrow write flags");
    cpu_read(20, "R10 flags after forwarded lookup");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all responses seen", 36'(exp_q.size()), 36'h0);
    report();
  end
endmodule